// File: doc/BRIEF.md
# Synchronous Character Receiver with SYN Hunt

This block turns a bit-synchronous serial stream into characters. It runs on the rising edge of a 1X receive clock, so each rising edge brings in exactly one bit. When the enable goes high, the receiver hunts one bit at a time for a programmable sync pattern (SYN1). It can also require a second sync character (SYN2) at character distance before it declares lock. From then on it assembles characters of 5 to 8 data bits, least significant bit first, with an optional parity bit. Each character goes into a holding register that a host reads through a simple strobe port.

Four sticky status flags report on the stream: ready, SYN-detect, parity-error/DLE-detect and overrun. A stripping option stops fill characters from reaching the holding register. In normal mode the fill characters are SYN characters. In transparent mode they are DLE escape characters. The strip decisions look at character pairs, so a doubled SYN1 or a doubled DLE still delivers one copy of the character.

Top module: `sync_char_rx`

## Requirements
- R1: When `rx_en` is first sampled high, that rising edge only starts the hunt. The bit present on that edge is ignored, and the first bit is taken on the next rising edge.
- R2: In hunt, the most recent frame-width bits are compared with SYN1 after every new bit, at any bit offset. The frame width is the data length plus one when parity is on, and the compared frame then carries SYN1's parity bit. Lock needs at least a frame-width of bits since the hunt started.
- R3: With `single_syn`=0, the character that follows a SYN1 match must equal SYN2, or the receiver goes back to hunt with an empty window. The sequence SYN1, SYN1, SYN2 therefore does not give lock, and SYN1, SYN2 does.
- R4: Characters used to gain lock never reach the holding register, and `syn_det` is set when lock is gained.
- R5: After lock, characters arrive least significant bit first. `len_code` 00/01/10/11 selects 5/6/7/8 data bits. Each kept character is zero-extended into `hold_data`, and `ready` rises after the edge that samples its last bit.
- R6: Loading a character while `ready` is still set raises `overrun`, which then stays set while enabled.
- R7: With `par_en`=1, a parity bit follows the data (`par_odd`=1 odd, 0 even). A mismatch sets `pde`, and the character is still loaded.
- R8: With `strip_en`=1 and `transparent`=0: if `single_syn`=1, every SYN1 is dropped. If `single_syn`=0, a SYN1 is dropped and so is a SYN2 right after it. Of two SYN1s in a row, only the first is dropped.
- R9: With `strip_en`=1 and `transparent`=1, a DLE is dropped and so is a SYN1 right after it. Of two DLEs in a row, the second is kept, and a SYN1 after that kept DLE is kept.
- R10: With `transparent`=1 and `par_en`=0, a DLE that does not complete a DLE-DLE pair sets `pde`. With parity on, a DLE with good parity does not set it.
- R11: After lock, `syn_det` is set by SYN1 (single, normal), by SYN1 then SYN2 (double, normal), or by DLE then SYN1 (transparent). Stripping does not stop this.
- R12: A `rd_hold` strobe clears `ready`, and a `rd_status` strobe clears `syn_det`, on the edge that samples them.
- R13: After reset, or on any edge with `rx_en` low, the receiver is idle, the partial character is dropped and `ready`, `overrun`, `pde` and `syn_det` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1X receive clock; one bit is sampled per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| rx_data | input | 1 | Serial input |
| len_code | input | 2 | Data length code (00=5 .. 11=8) |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| single_syn | input | 1 | 1 = one SYN1 locks, 0 = SYN1 then SYN2 |
| transparent | input | 1 | DLE-based fill and detection |
| strip_en | input | 1 | Drop fill characters |
| syn1 | input | 8 | First sync character |
| syn2 | input | 8 | Second sync character |
| dle | input | 8 | Escape character |
| rd_hold | input | 1 | Holding register read strobe |
| rd_status | input | 1 | Status read strobe |
| hold_data | output | 8 | Holding register |
| ready | output | 1 | Holding register has a character |
| syn_det | output | 1 | Sync sequence seen |
| pde | output | 1 | Parity error or DLE seen |
| overrun | output | 1 | Character lost by overwrite |

## Verification
Every result is registered once behind the edge that samples its cause. Lock, `syn_det`, `ready`, `hold_data`, `pde` and `overrun` change after the edge that takes in the final bit of the relevant frame. Read strobes and disable take effect after the edge that samples them. The bench drives bits on falling edges and checks two nanoseconds after the rising edge that completes a frame, so each check sees the state that edge produced. Read strobes are raised between edges and ride on the next bit edge, so no extra clock edge ever shifts a stray bit into the receiver.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

    localparam int MIN_LEN = 5;
    localparam int CHAR_W  = MIN_LEN + 3;
    localparam int FRAME_W = CHAR_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_PAIR,
        ST_ASSEM
    } rx_state_e;

    typedef struct packed {
        logic [1:0] len_code;
        logic       par_en;
        logic       par_odd;
        logic       single_syn;
        logic       transparent;
        logic       strip;
    } rx_cfg_t;

    typedef struct packed {
        logic              par;
        logic [CHAR_W-1:0] data;
    } rx_frame_t;

    function automatic logic [CNT_W-1:0] data_bits(rx_cfg_t c);
        return CNT_W'(MIN_LEN) + CNT_W'(c.len_code);
    endfunction

    function automatic logic [CNT_W-1:0] frame_bits(rx_cfg_t c);
        return data_bits(c) + CNT_W'(c.par_en);
    endfunction

    function automatic logic [CHAR_W-1:0] char_mask(rx_cfg_t c);
        logic [CHAR_W-1:0] m;
        for (int i = 0; i < CHAR_W; i++) begin
            m[i] = (i < int'(data_bits(c)));
        end
        return m;
    endfunction

    function automatic logic par_of(logic [CHAR_W-1:0] d, rx_cfg_t c);
        return (^(d & char_mask(c))) ^ c.par_odd;
    endfunction

    function automatic rx_frame_t frame_of(logic [CHAR_W-1:0] d, rx_cfg_t c);
        rx_frame_t f;
        f.data = d & char_mask(c);
        f.par  = c.par_en ? par_of(d, c) : 1'b0;
        return f;
    endfunction

endpackage

// File: rtl/sync_rx_shifter.sv
module sync_rx_shifter
    import sync_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  logic      shift_en,
    input  logic      bit_in,
    input  rx_cfg_t   cfg,
    output rx_frame_t frame_in,
    output logic      window_full
);

    logic [FRAME_W-1:0] sr_q;
    logic [FRAME_W-1:0] sr_next;
    logic [FRAME_W-1:0] win;
    logic [CNT_W-1:0]   fill_q;
    logic [CNT_W-1:0]   fill_next;
    logic [CNT_W-1:0]   fb;
    logic [CNT_W-1:0]   db;

    always_comb begin
        fb        = frame_bits(cfg);
        db        = data_bits(cfg);
        sr_next   = {bit_in, sr_q[FRAME_W-1:1]};
        fill_next = (fill_q == CNT_W'(FRAME_W)) ? fill_q : fill_q + 1'b1;
        win       = sr_next >> (CNT_W'(FRAME_W) - fb);
        frame_in.data = win[CHAR_W-1:0] & char_mask(cfg);
        frame_in.par  = cfg.par_en ? win[db] : 1'b0;
        window_full   = shift_en && (fill_next >= fb);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            sr_q   <= '0;
            fill_q <= '0;
        end else if (shift_en) begin
            sr_q   <= sr_next;
            fill_q <= fill_next;
        end
    end

endmodule

// File: rtl/sync_rx_seq.sv
module sync_rx_seq
    import sync_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  rx_cfg_t           cfg,
    input  logic [CHAR_W-1:0] syn1,
    input  logic [CHAR_W-1:0] syn2,
    input  rx_frame_t         frame_in,
    input  logic              window_full,
    output rx_state_e         state,
    output logic              restart,
    output logic              shift_en,
    output logic              char_valid,
    output logic              sync_evt
);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] bcnt_q, bcnt_d;
    logic             frame_end;
    logic             hit1;
    logic             hit2;

    always_comb begin
        hit1      = (frame_in == frame_of(syn1, cfg));
        hit2      = (frame_in == frame_of(syn2, cfg));
        frame_end = ((bcnt_q + 1'b1) == frame_bits(cfg));
        state_d    = state_q;
        bcnt_d     = bcnt_q;
        restart    = 1'b0;
        shift_en   = 1'b0;
        char_valid = 1'b0;
        sync_evt   = 1'b0;
        if (!rx_en) begin
            state_d = ST_IDLE;
            restart = 1'b1;
            bcnt_d  = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_HUNT;
                    restart = 1'b1;
                    bcnt_d  = '0;
                end
                ST_HUNT: begin
                    shift_en = 1'b1;
                    if (window_full && hit1) begin
                        bcnt_d = '0;
                        if (cfg.single_syn) begin
                            state_d  = ST_ASSEM;
                            sync_evt = 1'b1;
                        end else begin
                            state_d = ST_PAIR;
                        end
                    end
                end
                ST_PAIR: begin
                    shift_en = 1'b1;
                    bcnt_d   = bcnt_q + 1'b1;
                    if (frame_end) begin
                        bcnt_d = '0;
                        if (hit2) begin
                            state_d  = ST_ASSEM;
                            sync_evt = 1'b1;
                        end else begin
                            state_d = ST_HUNT;
                            restart = 1'b1;
                        end
                    end
                end
                default: begin
                    shift_en = 1'b1;
                    bcnt_d   = bcnt_q + 1'b1;
                    if (frame_end) begin
                        bcnt_d     = '0;
                        char_valid = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            bcnt_q  <= bcnt_d;
        end
    end

    assign state = state_q;

    assert_idle_after_disable_R13: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> state_q == ST_IDLE);

    assert_hunt_after_enable_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && rx_en) |=> state_q == ST_HUNT);

    assert_no_char_before_lock_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_ASSEM) |-> !char_valid);

endmodule

// File: rtl/sync_rx_classify.sv
module sync_rx_classify
    import sync_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              char_valid,
    input  rx_cfg_t           cfg,
    input  logic [CHAR_W-1:0] syn1,
    input  logic [CHAR_W-1:0] syn2,
    input  logic [CHAR_W-1:0] dle,
    input  rx_frame_t         frame,
    output logic              keep,
    output logic              syn_hit,
    output logic              pde_hit
);

    logic              lead_q, lead_d;
    logic              fill;
    logic              dle_hit;
    logic              par_err;
    logic              is1, is2, isd;
    logic [CHAR_W-1:0] m;

    always_comb begin
        m       = char_mask(cfg);
        is1     = (frame.data == (syn1 & m));
        is2     = (frame.data == (syn2 & m));
        isd     = (frame.data == (dle & m));
        fill    = 1'b0;
        syn_hit = 1'b0;
        dle_hit = 1'b0;
        lead_d  = lead_q;
        if (char_valid) begin
            lead_d = 1'b0;
            if (cfg.transparent) begin
                if (lead_q) begin
                    if (is1) begin
                        fill    = 1'b1;
                        syn_hit = 1'b1;
                    end
                end else if (isd) begin
                    fill    = 1'b1;
                    dle_hit = !cfg.par_en;
                    lead_d  = 1'b1;
                end
            end else if (cfg.single_syn) begin
                if (is1) begin
                    fill    = 1'b1;
                    syn_hit = 1'b1;
                end
            end else if (lead_q) begin
                if (is2) begin
                    fill    = 1'b1;
                    syn_hit = 1'b1;
                end
            end else if (is1) begin
                fill   = 1'b1;
                lead_d = 1'b1;
            end
        end
        par_err = char_valid && cfg.par_en && (frame.par != par_of(frame.data, cfg));
        keep    = !(fill && cfg.strip);
        pde_hit = dle_hit || par_err;
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            lead_q <= 1'b0;
        end else begin
            lead_q <= lead_d;
        end
    end

    assert_second_dle_silent_R10: assert property (@(posedge clk) disable iff (rst)
        (char_valid && cfg.transparent && lead_q && isd && !cfg.par_en
         && (frame.par == par_of(frame.data, cfg))) |-> !pde_hit);

endmodule

// File: rtl/sync_rx_hold.sv
module sync_rx_hold
    import sync_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_data,
    input  logic              syn_evt,
    input  logic              pde_evt,
    input  logic              rd_hold,
    input  logic              rd_status,
    output logic [CHAR_W-1:0] hold_q,
    output logic              ready_q,
    output logic              syn_q,
    output logic              pde_q,
    output logic              ovr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            ready_q <= 1'b0;
            syn_q   <= 1'b0;
            pde_q   <= 1'b0;
            ovr_q   <= 1'b0;
        end else if (clr) begin
            ready_q <= 1'b0;
            syn_q   <= 1'b0;
            pde_q   <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (load) begin
                hold_q  <= load_data;
                ready_q <= 1'b1;
                if (ready_q && !rd_hold) begin
                    ovr_q <= 1'b1;
                end
            end else if (rd_hold) begin
                ready_q <= 1'b0;
            end
            if (syn_evt) begin
                syn_q <= 1'b1;
            end else if (rd_status) begin
                syn_q <= 1'b0;
            end
            if (pde_evt) begin
                pde_q <= 1'b1;
            end
        end
    end

    assert_ready_on_load_R5: assert property (@(posedge clk) disable iff (rst)
        load |=> (ready_q && hold_q == $past(load_data)));

    assert_overrun_on_overwrite_R6: assert property (@(posedge clk) disable iff (rst)
        (load && ready_q && !rd_hold) |=> ovr_q);

    assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (ovr_q && !clr) |=> ovr_q);

    assert_read_clears_ready_R12: assert property (@(posedge clk) disable iff (rst)
        (rd_hold && !load && !clr) |=> !ready_q);

    assert_disable_clears_flags_R13: assert property (@(posedge clk) disable iff (rst)
        clr |=> !(ready_q || syn_q || pde_q || ovr_q));

endmodule

// File: rtl/sync_char_rx.sv
module sync_char_rx
    import sync_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              rx_data,
    input  logic [1:0]        len_code,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              single_syn,
    input  logic              transparent,
    input  logic              strip_en,
    input  logic [CHAR_W-1:0] syn1,
    input  logic [CHAR_W-1:0] syn2,
    input  logic [CHAR_W-1:0] dle,
    input  logic              rd_hold,
    input  logic              rd_status,
    output logic [CHAR_W-1:0] hold_data,
    output logic              ready,
    output logic              syn_det,
    output logic              pde,
    output logic              overrun
);

    rx_cfg_t           cfg;
    rx_frame_t         frame_in;
    rx_state_e         state;
    logic              window_full;
    logic              restart;
    logic              shift_en;
    logic              char_valid;
    logic              sync_evt;
    logic              keep;
    logic              syn_hit;
    logic              pde_hit;
    logic              load;
    logic              clr;
    logic [CHAR_W-1:0] mask;

    always_comb begin
        cfg.len_code    = len_code;
        cfg.par_en      = par_en;
        cfg.par_odd     = par_odd;
        cfg.single_syn  = single_syn;
        cfg.transparent = transparent;
        cfg.strip       = strip_en;
        mask            = char_mask(cfg);
        load            = char_valid && keep;
        clr             = !rx_en || (state == ST_IDLE);
    end

    sync_rx_shifter u_shift (
        .clk         (clk),
        .rst         (rst),
        .restart     (restart),
        .shift_en    (shift_en),
        .bit_in      (rx_data),
        .cfg         (cfg),
        .frame_in    (frame_in),
        .window_full (window_full)
    );

    sync_rx_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .rx_en       (rx_en),
        .cfg         (cfg),
        .syn1        (syn1),
        .syn2        (syn2),
        .frame_in    (frame_in),
        .window_full (window_full),
        .state       (state),
        .restart     (restart),
        .shift_en    (shift_en),
        .char_valid  (char_valid),
        .sync_evt    (sync_evt)
    );

    sync_rx_classify u_cls (
        .clk        (clk),
        .rst        (rst),
        .active     (state == ST_ASSEM),
        .char_valid (char_valid),
        .cfg        (cfg),
        .syn1       (syn1),
        .syn2       (syn2),
        .dle        (dle),
        .frame      (frame_in),
        .keep       (keep),
        .syn_hit    (syn_hit),
        .pde_hit    (pde_hit)
    );

    sync_rx_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .load      (load),
        .load_data (frame_in.data),
        .syn_evt   (sync_evt || (char_valid && syn_hit)),
        .pde_evt   (char_valid && pde_hit),
        .rd_hold   (rd_hold),
        .rd_status (rd_status),
        .hold_q    (hold_data),
        .ready_q   (ready),
        .syn_q     (syn_det),
        .pde_q     (pde),
        .ovr_q     (overrun)
    );

    assert_zero_extend_R5: assert property (@(posedge clk) disable iff (rst)
        load |=> ((hold_data & ~$past(mask)) == '0));

    assert_lock_not_loaded_R4: assert property (@(posedge clk) disable iff (rst)
        sync_evt |-> !load);

endmodule

// File: tb/sim_sync_char_rx.sv
module sim_sync_char_rx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b0;
    logic       rx_data = 1'b1;
    logic [1:0] len_code = 2'b11;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       single_syn = 1'b1;
    logic       transparent = 1'b0;
    logic       strip_en = 1'b0;
    logic [7:0] syn1 = 8'h16;
    logic [7:0] syn2 = 8'h69;
    logic [7:0] dle = 8'h10;
    logic       rd_hold = 1'b0;
    logic       rd_status = 1'b0;
    logic [7:0] hold_data;
    logic       ready, syn_det, pde, overrun;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic [8:0] fr;
    int   fn;

    // {len_code, par_en, par_odd, data, expected hold}
    localparam logic [19:0] VEC [8] = '{
        20'hCA5A5, 20'h0FF1F, 20'h4C909, 20'h88000,
        20'hE3C3C, 20'hF7E7E, 20'h30B0B, 20'hAF373
    };

    always #10 clk = ~clk;

    sync_char_rx u0 (
        .clk(clk), .rst(rst), .rx_en(rx_en), .rx_data(rx_data),
        .len_code(len_code), .par_en(par_en), .par_odd(par_odd),
        .single_syn(single_syn), .transparent(transparent), .strip_en(strip_en),
        .syn1(syn1), .syn2(syn2), .dle(dle),
        .rd_hold(rd_hold), .rd_status(rd_status),
        .hold_data(hold_data), .ready(ready), .syn_det(syn_det),
        .pde(pde), .overrun(overrun)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // one bit time; read strobes set beforehand are taken on this edge
    task automatic step(input logic b);
        @(negedge clk);
        rx_data = b;
        @(posedge clk);
        #2;
        rd_hold = 1'b0;
        rd_status = 1'b0;
    endtask

    function automatic logic ref_par(input logic [7:0] d);
        logic p = 1'b0;
        for (int i = 0; i < 5 + int'(len_code); i++) p ^= d[i];
        return par_odd ? ~p : p;
    endfunction

    task automatic mk(input logic [7:0] d, input logic flip);
        fr = '0;
        fn = 5 + int'(len_code);
        for (int i = 0; i < fn; i++) fr[i] = d[i];
        if (par_en) begin
            fr[fn] = ref_par(d) ^ flip;
            fn++;
        end
    endtask

    task automatic send_range(input int a, input int b);
        for (int i = a; i < b; i++) step(fr[i]);
    endtask

    task automatic send_char(input logic [7:0] d);
        mk(d, 1'b0);
        send_range(0, fn);
    endtask

    task automatic restart_rx();
        rx_en = 1'b0;
        step(1'b1);
        rx_en = 1'b1;
        step(1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        step(1'b1);
        step(1'b1);
        rst = 1'b0;
        step(1'b1);
        // R13: reset / disabled state
        chk("R13", "reset ready", ready, 0);
        chk("R13", "reset syn_det", syn_det, 0);
        chk("R13", "reset pde", pde, 0);
        chk("R13", "reset overrun", overrun, 0);
        chk("R13", "reset hold", hold_data, 0);

        // R1: bit on the enabling edge is ignored
        mk(syn1, 1'b0);
        rx_en = 1'b1;
        step(fr[0]);
        send_range(1, fn);
        chk("R1", "no lock from enable-edge bit", syn_det, 0);
        send_char(syn1);
        chk("R1", "lock one full SYN1 later", syn_det, 1);

        // R2: bit-offset hunt
        restart_rx();
        step(1'b1);
        step(1'b1);
        mk(syn1, 1'b0);
        send_range(0, fn - 1);
        chk("R2", "no lock before last SYN1 bit", syn_det, 0);
        send_range(fn - 1, fn);
        chk("R2", "lock at offset", syn_det, 1);

        // R4 R5 R7: vector table
        for (int v = 0; v < 8; v++) begin
            {len_code, par_en, par_odd} = VEC[v][19:16];
            restart_rx();
            send_char(syn1);
            chk("R4", "sync char not loaded", {syn_det, ready}, 2'b10);
            send_char(VEC[v][15:8]);
            chk("R5", "zero-extended hold", hold_data, VEC[v][7:0]);
            chk("R5", "ready after char", ready, 1);
            chk("R7", "no parity error", pde, 0);
        end
        len_code = 2'b11;
        par_en = 1'b0;
        par_odd = 1'b0;

        // R3: double SYN
        single_syn = 1'b0;
        restart_rx();
        send_char(syn1);
        send_char(syn1);
        send_char(syn2);
        send_char(8'h55);
        chk("R3", "SYN1 SYN1 SYN2 no lock", {syn_det, ready}, 2'b00);
        restart_rx();
        send_char(syn1);
        chk("R3", "no lock on SYN1 alone", syn_det, 0);
        send_char(syn2);
        chk("R4", "lock on SYN1 SYN2, nothing loaded", {syn_det, ready}, 2'b10);
        send_char(8'h55);
        chk("R3", "char after double lock", hold_data, 8'h55);

        // R6 R12: overrun and reads
        send_char(8'h33);
        chk("R6", "overrun set", overrun, 1);
        chk("R6", "newest char held", hold_data, 8'h33);
        mk(8'h0F, 1'b0);
        rd_hold = 1'b1;
        rd_status = 1'b1;
        send_range(0, 1);
        chk("R12", "rd_hold clears ready", ready, 0);
        chk("R12", "rd_status clears syn_det", syn_det, 0);
        send_range(1, fn);
        chk("R6", "overrun sticky", {ready, overrun}, 2'b11);

        // R7: parity error
        single_syn = 1'b1;
        par_en = 1'b1;
        restart_rx();
        send_char(syn1);
        mk(8'h3C, 1'b1);
        send_range(0, fn);
        chk("R7", "bad parity flagged", pde, 1);
        chk("R7", "bad parity char loaded", hold_data, 8'h3C);
        par_en = 1'b0;

        // R8 R11: normal-mode stripping, single
        strip_en = 1'b1;
        restart_rx();
        send_char(syn1);
        rd_status = 1'b1;
        send_char(syn1);
        chk("R8", "single SYN1 stripped", ready, 0);
        chk("R11", "SYN1 sets syn_det after lock", syn_det, 1);
        send_char(8'h41);
        chk("R8", "data kept", hold_data, 8'h41);

        // R8 R11: normal-mode stripping, double
        single_syn = 1'b0;
        restart_rx();
        send_char(syn1);
        send_char(syn2);
        rd_status = 1'b1;
        send_char(syn1);
        send_char(syn2);
        chk("R8", "SYN1 SYN2 stripped", ready, 0);
        chk("R11", "SYN1 SYN2 sets syn_det", syn_det, 1);
        send_char(syn1);
        send_char(syn1);
        chk("R8", "second SYN1 of pair kept", {ready, hold_data}, {1'b1, 8'h16});
        rd_hold = 1'b1;
        send_char(syn1);
        send_char(8'h41);
        chk("R8", "lone SYN1 stripped before data", {hold_data, overrun}, {8'h41, 1'b0});

        // R9 R10 R11: transparent stripping
        single_syn = 1'b1;
        transparent = 1'b1;
        restart_rx();
        send_char(syn1);
        chk("R11", "transparent lock", syn_det, 1);
        rd_status = 1'b1;
        send_char(dle);
        chk("R9", "DLE stripped", ready, 0);
        chk("R10", "DLE sets pde", pde, 1);
        chk("R11", "DLE alone no syn_det", syn_det, 0);
        send_char(syn1);
        chk("R9", "DLE SYN1 stripped", ready, 0);
        chk("R11", "DLE SYN1 sets syn_det", syn_det, 1);
        send_char(dle);
        send_char(dle);
        chk("R9", "second DLE kept", {ready, hold_data}, {1'b1, 8'h10});
        rd_hold = 1'b1;
        send_char(syn1);
        chk("R9", "SYN1 after kept DLE kept", {ready, hold_data, overrun}, {1'b1, 8'h16, 1'b0});

        // R10: parity on, good DLE does not set pde
        par_en = 1'b1;
        restart_rx();
        send_char(syn1);
        send_char(dle);
        chk("R10", "DLE with parity no pde", {pde, ready}, 2'b00);
        par_en = 1'b0;
        transparent = 1'b0;
        strip_en = 1'b0;

        // R13: disable mid-character
        restart_rx();
        send_char(syn1);
        send_char(8'h41);
        send_char(8'h42);
        mk(8'h22, 1'b0);
        send_range(0, 4);
        rx_en = 1'b0;
        step(1'b1);
        chk("R13", "disable clears flags", {ready, syn_det, pde, overrun}, 4'b0000);
        rx_en = 1'b1;
        step(1'b1);
        send_char(syn1);
        send_char(8'h22);
        chk("R13", "clean restart after disable", {ready, hold_data, overrun}, {1'b1, 8'h22, 1'b0});

        finish_up();
    end

endmodule